// File: doc/BRIEF.md
# Multiply-Accumulate Unit

This block multiplies two signed operand words and folds the result into a private accumulator that is twice the operand width. The accumulator is stored as two halves, a high word and a low word. A command port accepts one operation per clock. Multiply-and-add and multiply-and-subtract use the operand product cut down to one word and sign-extended to the accumulator width. Read-and-clear hands back the low half and zeroes the whole accumulator in the same step.

A separate write port loads either half, or both halves, from one data word. This lets a processor save and restore the accumulator through its special-register moves. Both halves are also visible directly as registered outputs. Every command completes at the next clock edge, so a command issued straight after an accumulate acts on the updated value without any stall.

Top module: `macc_core`

## Requirements
- R1: The accumulator is the concatenation {acc_hi, acc_lo}: acc_hi holds bits 63..32 and acc_lo holds bits 31..0. Both are registered outputs.
- R2: A command with cmd_op = 0 (multiply-and-add) takes the low 32 bits of cmd_a × cmd_b as a signed value, sign-extends it to 64 bits and adds it to the accumulator. The new value shows on acc_hi/acc_lo one cycle after the command.
- R3: A command with cmd_op = 1 (multiply-and-subtract) subtracts the same sign-extended, truncated product from the accumulator. The result shows one cycle after the command.
- R4: A command with cmd_op = 2 (read-and-clear) puts the accumulator's low half, as it stood before the command, on rsp_data with rsp_valid high one cycle after the command. In that same cycle both halves read zero.
- R5: Commands may follow each other on consecutive cycles. Each command acts on the accumulator as left by the one before it.
- R6: With no command active, wr_lo_en loads wr_data into the low half and wr_hi_en loads it into the high half, one cycle later. Both enables together load both halves.
- R7: If a command with cmd_op 0, 1 or 2 is valid in the same cycle as a write, the command decides the accumulator and the write is dropped.
- R8: cmd_op = 3 is reserved. It leaves the accumulator unchanged and raises no response.
- R9: A synchronous active-high reset clears both halves and rsp_valid at the next clock edge.
- R10: Carries and borrows cross from the low half into the high half, so the 64-bit result wraps modulo 2^64.
- R11: rsp_valid is low in every cycle that does not follow a read-and-clear command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 add, 1 subtract, 2 read-and-clear, 3 reserved |
| cmd_a | input | 32 | First operand |
| cmd_b | input | 32 | Second operand |
| wr_hi_en | input | 1 | Load high half from wr_data |
| wr_lo_en | input | 1 | Load low half from wr_data |
| wr_data | input | 32 | Data for half writes |
| acc_hi | output | 32 | Accumulator bits 63..32 |
| acc_lo | output | 32 | Accumulator bits 31..0 |
| rsp_valid | output | 1 | Read-and-clear result present |
| rsp_data | output | 32 | Low half captured by read-and-clear |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. This covers the accumulator halves after an add, subtract, write or reset, and the response word and its valid flag after a read-and-clear. The driver changes inputs on the falling edge and, at the same moment, queues the accumulator and response values that the requirements predict for the next rising edge. The monitor takes one queued item shortly after each rising edge, so one queue entry stands for exactly one edge of latency. Back-to-back commands, colliding writes and a mid-run reset are all checked with the same one-edge alignment.

// File: rtl/macc_pkg.sv
package macc_pkg;
  typedef enum logic [1:0] {
    OP_MADD  = 2'd0,
    OP_MSUB  = 2'd1,
    OP_RDCLR = 2'd2,
    OP_RSVD  = 2'd3
  } macc_op_e;
endpackage

// File: rtl/macc_mult.sv
module macc_mult #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]   op_a,
  input  logic [DW-1:0]   op_b,
  output logic [2*DW-1:0] prod_ext
);
  localparam int AW = 2 * DW;

  // The low word of a product is identical for signed and unsigned operands.
  logic [DW-1:0] prod_word;
  assign prod_word = op_a * op_b;
  assign prod_ext  = {{(AW-DW){prod_word[DW-1]}}, prod_word};
endmodule

// File: rtl/macc_acc.sv
module macc_acc import macc_pkg::*; #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  macc_op_e        cmd_op,
  input  logic [2*DW-1:0] prod_ext,
  input  logic            wr_hi_en,
  input  logic            wr_lo_en,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   acc_hi,
  output logic [DW-1:0]   acc_lo
);
  localparam int AW = 2 * DW;

  logic          cmd_active;
  logic [AW-1:0] acc_now;
  logic [AW-1:0] acc_next;

  assign cmd_active = cmd_valid && (cmd_op != OP_RSVD);
  assign acc_now    = {acc_hi, acc_lo};

  always_comb begin
    acc_next = acc_now;
    if (cmd_active) begin
      case (cmd_op)
        OP_MADD:  acc_next = acc_now + prod_ext;
        OP_MSUB:  acc_next = acc_now - prod_ext;
        default:  acc_next = '0;
      endcase
    end else begin
      if (wr_hi_en) acc_next[AW-1:DW] = wr_data;
      if (wr_lo_en) acc_next[DW-1:0]  = wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_hi <= '0;
      acc_lo <= '0;
    end else begin
      acc_hi <= acc_next[AW-1:DW];
      acc_lo <= acc_next[DW-1:0];
    end
  end

  assert_madd_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_MADD) |=>
      ({acc_hi, acc_lo} == $past({acc_hi, acc_lo}) + $past(prod_ext)));

  assert_msub_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_MSUB) |=>
      ({acc_hi, acc_lo} == $past({acc_hi, acc_lo}) - $past(prod_ext)));

  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_RDCLR) |=> (acc_hi == '0 && acc_lo == '0));

  assert_write_lo_R6: assert property (@(posedge clk) disable iff (rst)
    (!cmd_active && wr_lo_en) |=> (acc_lo == $past(wr_data)));

  assert_write_hi_R6: assert property (@(posedge clk) disable iff (rst)
    (!cmd_active && wr_hi_en) |=> (acc_hi == $past(wr_data)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!cmd_active && !wr_hi_en && !wr_lo_en) |=> ($stable(acc_hi) && $stable(acc_lo)));

  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (acc_hi == '0 && acc_lo == '0));
endmodule

// File: rtl/macc_rsp.sv
module macc_rsp import macc_pkg::*; #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  macc_op_e      cmd_op,
  input  logic [DW-1:0] acc_lo,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  logic take;
  assign take = cmd_valid && (cmd_op == OP_RDCLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= take;
      if (take) rsp_data <= acc_lo;
    end
  end

  assert_rsp_reset_R9: assert property (@(posedge clk) rst |=> !rsp_valid);
endmodule

// File: rtl/macc_core.sv
module macc_core import macc_pkg::*; #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_a,
  input  logic [DW-1:0] cmd_b,
  input  logic          wr_hi_en,
  input  logic          wr_lo_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] acc_hi,
  output logic [DW-1:0] acc_lo,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  localparam int AW = 2 * DW;

  macc_op_e      op;
  logic [AW-1:0] prod_ext;

  assign op = macc_op_e'(cmd_op);

  macc_mult #(.DW(DW)) u_mult (
    .op_a     (cmd_a),
    .op_b     (cmd_b),
    .prod_ext (prod_ext)
  );

  macc_acc #(.DW(DW)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (op),
    .prod_ext  (prod_ext),
    .wr_hi_en  (wr_hi_en),
    .wr_lo_en  (wr_lo_en),
    .wr_data   (wr_data),
    .acc_hi    (acc_hi),
    .acc_lo    (acc_lo)
  );

  macc_rsp #(.DW(DW)) u_rsp (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (op),
    .acc_lo    (acc_lo),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  assert_rdclr_rsp_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == OP_RDCLR) |=> (rsp_valid && rsp_data == $past(acc_lo)));

  assert_rsp_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && op == OP_RDCLR) |=> !rsp_valid);

  assert_cmd_beats_write_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == OP_RDCLR && (wr_hi_en || wr_lo_en)) |=>
      (acc_hi == '0 && acc_lo == '0));
endmodule

// File: tb/sim_macc_core.sv
module sim_macc_core;
  typedef struct {
    logic [63:0] acc;
    logic        rv;
    logic [31:0] rd;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [31:0] cmd_a = '0, cmd_b = '0;
  logic        wr_hi_en = 1'b0, wr_lo_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] acc_hi, acc_lo, rsp_data;
  logic        rsp_valid;

  exp_t        q[$];
  logic [63:0] m_acc = '0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  macc_core u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_a(cmd_a), .cmd_b(cmd_b), .wr_hi_en(wr_hi_en), .wr_lo_en(wr_lo_en),
    .wr_data(wr_data), .acc_hi(acc_hi), .acc_lo(acc_lo),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  function automatic logic [63:0] sprod(logic [31:0] a, logic [31:0] b);
    logic [63:0] full;
    full = {32'd0, a} * {32'd0, b};
    return {{32{full[31]}}, full[31:0]};
  endfunction

  task automatic step(input logic r, input logic v, input logic [1:0] op,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic wh, input logic wl, input logic [31:0] wd,
                      input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; cmd_valid = v; cmd_op = op; cmd_a = a; cmd_b = b;
    wr_hi_en = wh; wr_lo_en = wl; wr_data = wd;
    e.rv = 1'b0; e.rd = '0; e.tag = tag;
    if (r) m_acc = '0;
    else if (v && op != 2'd3) begin
      case (op)
        2'd0: m_acc = m_acc + sprod(a, b);
        2'd1: m_acc = m_acc - sprod(a, b);
        default: begin e.rv = 1'b1; e.rd = m_acc[31:0]; m_acc = '0; end
      endcase
    end else begin
      if (wh) m_acc[63:32] = wd;
      if (wl) m_acc[31:0]  = wd;
    end
    e.acc = m_acc;
    q.push_back(e);
  endtask

  task automatic cmd(input logic [1:0] op, input logic [31:0] a,
                     input logic [31:0] b, input string tag);
    step(1'b0, 1'b1, op, a, b, 1'b0, 1'b0, '0, tag);
  endtask

  task automatic wr(input logic wh, input logic wl, input logic [31:0] wd,
                    input string tag);
    step(1'b0, 1'b0, 2'd0, '0, '0, wh, wl, wd, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 2'd0, '0, '0, 1'b0, 1'b0, '0, tag);
  endtask

  // Monitor: one queued expectation per rising edge.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if ({acc_hi, acc_lo} !== e.acc) begin
        errors++;
        $display("FAIL %s: acc actual %h_%h expected %h_%h", e.tag,
                 acc_hi, acc_lo, e.acc[63:32], e.acc[31:0]);
      end
      checks++;
      if (rsp_valid !== e.rv || (e.rv && rsp_data !== e.rd)) begin
        errors++;
        $display("FAIL %s: rsp actual %b/%h expected %b/%h", e.tag,
                 rsp_valid, rsp_data, e.rv, e.rd);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    step(1'b1, 1'b0, 2'd0, '0, '0, 1'b0, 1'b0, '0, "R9 reset");
    step(1'b1, 1'b0, 2'd0, '0, '0, 1'b0, 1'b0, '0, "R9 reset");
    idle("R11 idle after reset");
    // R2: basic, negative, truncated-to-zero, truncated-negative products
    cmd(2'd0, 32'd3, 32'd4, "R2 madd 3*4");
    cmd(2'd0, -32'sd5, 32'd7, "R2 madd -5*7");
    cmd(2'd0, 32'h0001_0000, 32'h0001_0000, "R2 madd truncated zero");
    cmd(2'd0, 32'h0000_FFFF, 32'h0000_FFFF, "R2 madd truncated negative");
    // R5/R4: read straight after accumulate
    cmd(2'd2, '0, '0, "R5 R4 rdclr after madd");
    idle("R11 quiet after read");
    // R1/R6: write halves, R10 carry into high half
    wr(1'b0, 1'b1, 32'hFFFF_FFFF, "R6 write lo");
    wr(1'b1, 1'b0, 32'h0000_0010, "R1 write hi");
    cmd(2'd0, 32'd1, 32'd1, "R10 carry into hi");
    cmd(2'd1, 32'd1, 32'd1, "R10 borrow from hi");
    cmd(2'd1, 32'd3, -32'sd2, "R3 msub negative product");
    cmd(2'd1, 32'd100, 32'd100, "R3 msub");
    // R7: command beats write
    step(1'b0, 1'b1, 2'd0, 32'd2, 32'd9, 1'b1, 1'b1, 32'hDEAD_BEEF, "R7 madd beats write");
    step(1'b0, 1'b1, 2'd2, '0, '0, 1'b1, 1'b1, 32'h1111_2222, "R7 rdclr beats write");
    // R8: reserved op
    wr(1'b1, 1'b1, 32'h0BAD_F00D, "R6 write both");
    cmd(2'd3, 32'd5, 32'd6, "R8 reserved op");
    idle("R8 R11 after reserved");
    // R10: borrow from zero wraps whole accumulator
    cmd(2'd2, '0, '0, "R4 clear");
    cmd(2'd1, 32'd1, 32'd1, "R10 wrap below zero");
    // R5: random back-to-back stream
    for (int i = 0; i < 60; i++) begin
      logic [31:0] ra, rb;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      ra = seed;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      rb = seed;
      cmd((i % 7 == 6) ? 2'd2 : {1'b0, ra[0]}, ra, rb, "R5 stream");
    end
    // R9: mid-run reset
    cmd(2'd0, 32'd77, 32'd3, "R2 before reset");
    step(1'b1, 1'b1, 2'd2, '0, '0, 1'b0, 1'b0, '0, "R9 mid-run reset");
    idle("R9 R11 after reset");
    idle("R9 tail");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule